// File: doc/BRIEF.md
# Signature Reuse Predictor Table

This block learns, per access signature, whether cache lines brought in by that signature tend to be touched again before they leave the cache. The signature is typically a hash of the program counter of the instruction that caused the fill. Hashing it is not part of this block. The block keeps one small saturating confidence counter per signature value, and it turns that counter into a 2-bit re-reference prediction. A re-reference-interval replacement engine uses that prediction when it inserts or promotes a line.

The block has two independent ports. On the query port, the replacement engine presents a signature together with a hit/miss flag. One cycle later it receives the prediction. A hit always promotes the line to immediate. A miss inserts the line at distant when its signature has shown no reuse, and at far otherwise. On the training port, the cache reports each evicted line. The report carries the signature that filled the line, a flag saying whether the line was reused during its lifetime, and the set it came from. Only evictions from sampled sets train the table. A set is sampled when the low bits of its index equal a fixed pattern, so a small group of sets stands in for the whole cache.

The production configuration uses a 14-bit signature, which gives 16K counters, and samples 32 to 64 sets. The defaults of this block are smaller so that it elaborates cheaply, and every width is a parameter.

Top module: `sigHitPredictor`

## Requirements
- R1: After reset every counter holds 1, so a miss query for any signature returns far (2'b10) until that signature is trained.
- R2: `predValid` is high exactly in the cycle after a cycle with `reqValid` high, and is low otherwise.
- R3: A valid query with `reqHit` high returns immediate (2'b00), whatever the counter value.
- R4: A valid miss query returns distant (2'b11) when the signature's counter is 0, and far (2'b10) when it is 1, 2 or 3. The value 2'b01 is never returned.
- R5: A sampled eviction with `trainReused` high increments the counter of `trainSig`, saturating at 3.
- R6: A sampled eviction with `trainReused` low decrements the counter of `trainSig`, saturating at 0.
- R7: An eviction whose `trainSet[SampleBits-1:0]` differs from `SamplePattern` leaves every counter unchanged. With `SampleBits` = 0, every set is sampled.
- R8: When a query and a training event name the same signature in the same cycle, the query returns the prediction of the counter value before the update.
- R9: Training events in consecutive cycles all take effect, including repeated events on the same signature. No training event is dropped.
- R10: Training one signature never changes the prediction for any other signature.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Query strobe |
| reqSig | input | SigW | Signature of the query |
| reqHit | input | 1 | Query is a cache hit (1) or a miss (0) |
| predValid | output | 1 | Prediction is present, one cycle after the query |
| predRrpv | output | 2 | Prediction: 0 immediate, 2 far, 3 distant |
| trainValid | input | 1 | Eviction report strobe |
| trainSig | input | SigW | Signature that filled the evicted line |
| trainSet | input | SetW | Set index of the evicted line |
| trainReused | input | 1 | Evicted line was reused while resident |

## Verification
On every cycle the assertions check four things. The one-cycle latency of `predValid` holds. Hits always come back immediate. Misses only ever come back far or distant. No training strobe reaches the table from an unsampled set. The other properties depend on the counter history of each signature, so only the bench's scenarios can show them. These are saturation at both ends, the reset value, independence between signatures, the pre-update value seen by a colliding query, and the fact that back-to-back training is not lost. The bench shows them by sweeping every signature and every set of a reduced configuration against an arithmetic model.

// File: rtl/sigpred_pkg.sv
package sigpred_pkg;
  localparam logic [1:0] RRPV_NEAR    = 2'd0;
  localparam logic [1:0] RRPV_FAR     = 2'd2;
  localparam logic [1:0] RRPV_DISTANT = 2'd3;
  localparam logic [1:0] CTR_INIT     = 2'd1;
  localparam logic [1:0] CTR_MAX      = 2'd3;

  typedef struct packed {
    logic readEn;   // capture the counter of the query signature
    logic trainEn;  // apply a training step to the counter of the training signature
    logic trainUp;  // step direction: 1 = up, 0 = down
  } ctlStrobes_t;
endpackage

// File: rtl/sigPredDatapath.sv
module sigPredDatapath
  import sigpred_pkg::*;
#(
  parameter int SigW = 11
) (
  input  logic            clk,
  input  logic            rstN,
  input  ctlStrobes_t     strb,
  input  logic [SigW-1:0] reqSig,
  input  logic [SigW-1:0] trainSig,
  output logic [1:0]      rdCtr
);
  localparam int Entries = 1 << SigW;

  logic [1:0] ctrTable [Entries];
  logic [1:0] trainOld;
  logic [1:0] trainNew;

  assign trainOld = ctrTable[trainSig];

  always_comb begin
    trainNew = trainOld;
    if (strb.trainUp) begin
      if (trainOld != CTR_MAX) trainNew = trainOld + 2'd1;
    end else begin
      if (trainOld != 2'd0) trainNew = trainOld - 2'd1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < Entries; i++) ctrTable[i] <= CTR_INIT;
    end else if (strb.trainEn) begin
      ctrTable[trainSig] <= trainNew;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            rdCtr <= CTR_INIT;
    else if (strb.readEn) rdCtr <= ctrTable[reqSig];
  end
endmodule

// File: rtl/sigPredCtrl.sv
module sigPredCtrl
  import sigpred_pkg::*;
#(
  parameter int SetW          = 11,
  parameter int SampleBits    = 5,
  parameter int SamplePattern = 0
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            reqValid,
  input  logic            reqHit,
  input  logic            trainValid,
  input  logic [SetW-1:0] trainSet,
  input  logic            trainReused,
  input  logic [1:0]      rdCtr,
  output ctlStrobes_t     strb,
  output logic            predValid,
  output logic [1:0]      predRrpv
);
  logic setSampled;
  logic validQ;
  logic hitQ;

  generate
    if (SampleBits == 0) begin : g_allSets
      logic unusedSet;
      assign unusedSet  = ^trainSet;
      assign setSampled = 1'b1;
    end else begin : g_someSets
      if (SampleBits < SetW) begin : g_hiBits
        logic unusedHi;
        assign unusedHi = ^trainSet[SetW-1:SampleBits];
      end
      assign setSampled = (trainSet[SampleBits-1:0] == SampleBits'(SamplePattern));
    end
  endgenerate

  always_comb begin
    strb.readEn  = reqValid;
    strb.trainEn = trainValid && setSampled;
    strb.trainUp = trainReused;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validQ <= 1'b0;
      hitQ   <= 1'b0;
    end else begin
      validQ <= reqValid;
      if (reqValid) hitQ <= reqHit;
    end
  end

  assign predValid = validQ;

  always_comb begin
    if (!validQ)            predRrpv = RRPV_NEAR;
    else if (hitQ)          predRrpv = RRPV_NEAR;
    else if (rdCtr == 2'd0) predRrpv = RRPV_DISTANT;
    else                    predRrpv = RRPV_FAR;
  end
endmodule

// File: rtl/sigHitPredictor.sv
module sigHitPredictor
  import sigpred_pkg::*;
#(
  parameter int SigW          = 11,
  parameter int SetW          = 11,
  parameter int SampleBits    = 5,
  parameter int SamplePattern = 0
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            reqValid,
  input  logic [SigW-1:0] reqSig,
  input  logic            reqHit,
  output logic            predValid,
  output logic [1:0]      predRrpv,
  input  logic            trainValid,
  input  logic [SigW-1:0] trainSig,
  input  logic [SetW-1:0] trainSet,
  input  logic            trainReused
);
  ctlStrobes_t ctrStrb;
  logic [1:0]  rdCtr;

  sigPredCtrl #(
    .SetW(SetW), .SampleBits(SampleBits), .SamplePattern(SamplePattern)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqHit(reqHit),
    .trainValid(trainValid), .trainSet(trainSet), .trainReused(trainReused),
    .rdCtr(rdCtr), .strb(ctrStrb),
    .predValid(predValid), .predRrpv(predRrpv)
  );

  sigPredDatapath #(.SigW(SigW)) u_dp (
    .clk(clk), .rstN(rstN), .strb(ctrStrb),
    .reqSig(reqSig), .trainSig(trainSig), .rdCtr(rdCtr)
  );
endmodule

// File: rtl/sigHitPredictorChecker.sv
module sigHitPredictorChecker
  import sigpred_pkg::*;
#(
  parameter int SetW          = 11,
  parameter int SampleBits    = 5,
  parameter int SamplePattern = 0
) (
  input logic            clk,
  input logic            rstN,
  input logic            reqValid,
  input logic            reqHit,
  input logic            predValid,
  input logic [1:0]      predRrpv,
  input logic            trainValid,
  input logic [SetW-1:0] trainSet,
  input ctlStrobes_t     ctrStrb
);
  logic inSample;
  generate
    if (SampleBits == 0) begin : g_all
      assign inSample = 1'b1;
    end else begin : g_some
      assign inSample = (trainSet[SampleBits-1:0] == SampleBits'(SamplePattern));
    end
  endgenerate

  p_valid_latency_r2: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> predValid);
  p_valid_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !predValid);
  p_hit_immediate_r3: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqHit) |=> (predRrpv == RRPV_NEAR));
  p_miss_far_or_distant_r4: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqHit) |=> (predRrpv == RRPV_FAR || predRrpv == RRPV_DISTANT));
  p_unsampled_quiet_r7: assert property (@(posedge clk) disable iff (!rstN)
    (trainValid && !inSample) |-> !ctrStrb.trainEn);
endmodule

bind sigHitPredictor sigHitPredictorChecker #(
  .SetW(SetW), .SampleBits(SampleBits), .SamplePattern(SamplePattern)
) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqHit(reqHit),
  .predValid(predValid), .predRrpv(predRrpv),
  .trainValid(trainValid), .trainSet(trainSet), .ctrStrb(ctrStrb)
);

// File: tb/sigHitPredictor_test.sv
`timescale 1ns/1ps
module sigHitPredictor_test;
  localparam int SigW = 4;
  localparam int SetW = 4;
  localparam int SampleBits = 2;
  localparam int SamplePattern = 1;
  localparam int NSig = 1 << SigW;
  localparam int NSet = 1 << SetW;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqHit = 1'b0;
  logic [SigW-1:0] reqSig = '0;
  logic predValid;
  logic [1:0] predRrpv;
  logic trainValid = 1'b0, trainReused = 1'b0;
  logic [SigW-1:0] trainSig = '0;
  logic [SetW-1:0] trainSet = '0;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;
  int model [NSig];

  always #10 clk = ~clk;

  sigHitPredictor #(.SigW(SigW), .SetW(SetW), .SampleBits(SampleBits),
                    .SamplePattern(SamplePattern)) uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqSig(reqSig), .reqHit(reqHit),
    .predValid(predValid), .predRrpv(predRrpv), .trainValid(trainValid),
    .trainSig(trainSig), .trainSet(trainSet), .trainReused(trainReused));

  task automatic check(string tag, int got, int exp);
    vectors++;
    if (got != exp) begin
      miscompares++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  function automatic int expPred(int ctr, bit hit);
    if (hit) return 0;
    return (ctr == 0) ? 3 : 2;
  endfunction

  // One cycle: inputs applied at a falling edge, result sampled at the next one.
  task automatic cycle(bit rv, int rs, bit rh, bit tv, int ts, int tset, bit tr, string tag);
    int exp;
    reqValid = rv; reqSig = SigW'(rs); reqHit = rh;
    trainValid = tv; trainSig = SigW'(ts); trainSet = SetW'(tset); trainReused = tr;
    exp = expPred(model[rs], rh);                       // pre-update value (R8)
    if (tv && ((tset % 4) == SamplePattern)) begin
      if (tr) model[ts] = (model[ts] == 3) ? 3 : model[ts] + 1;
      else    model[ts] = (model[ts] == 0) ? 0 : model[ts] - 1;
    end
    @(negedge clk);
    check({tag, " R2 valid"}, int'(predValid), int'(rv));
    if (rv) check(tag, int'(predRrpv), exp);
    reqValid = 0; trainValid = 0;
  endtask

  task automatic missSweep(string tag);
    for (int s = 0; s < NSig; s++) cycle(1, s, 0, 0, 0, 0, 0, tag);
  endtask

  // Trains every set for every signature back to back (R9)
  task automatic trainSweep(int mode, string tag);
    for (int s = 0; s < NSig; s++) begin
      for (int st = 0; st < NSet; st++) begin
        bit r;
        r = (mode == 0) ? 1'b0 : (mode == 1) ? 1'b1 : bit'(((st >> 2) ^ s) & 1);
        // concurrent query on another signature: R10
        cycle(1, (s + 5) % NSig, 0, 1, s, st, r, tag);
      end
      cycle(1, s, 0, 0, 0, 0, 0, tag);
    end
  endtask

  initial begin
    for (int i = 0; i < NSig; i++) model[i] = 1;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    check("R2 reset valid", int'(predValid), 0);
    missSweep("R1 reset far");
    for (int s = 0; s < NSig; s++) cycle(1, s, 1, 0, 0, 0, 0, "R3 hit immediate");
    // unsampled sets only, strong decrement pattern: no change
    for (int st = 0; st < NSet; st++)
      if ((st % 4) != SamplePattern) cycle(0, 0, 0, 1, 7, st, 0, "R7 unsampled");
    missSweep("R7 unchanged");
    trainSweep(0, "R6 decrement saturate");
    missSweep("R4 distant at zero");
    for (int s = 0; s < NSig; s++) cycle(1, s, 1, 0, 0, 0, 0, "R3 hit at zero");
    trainSweep(1, "R5 increment saturate");
    missSweep("R4 far at three");
    trainSweep(2, "R10 mixed training");
    missSweep("R10 mixed result");
    // R8: colliding query and update: counter of 3 at 1 then step down
    cycle(0, 0, 0, 1, 3, 1, 0, "R8 setup");
    cycle(0, 0, 0, 1, 3, 5, 0, "R8 setup");
    cycle(0, 0, 0, 1, 3, 9, 0, "R8 setup");
    cycle(1, 3, 0, 0, 0, 0, 0, "R8 at zero");
    cycle(0, 0, 0, 1, 3, 1, 1, "R8 setup up");
    cycle(1, 3, 0, 1, 3, 1, 0, "R8 pre-update");
    cycle(1, 3, 0, 0, 0, 0, 0, "R8 post-update");
    cycle(1, 3, 0, 1, 3, 13, 1, "R8 pre-update rise");
    cycle(1, 3, 0, 0, 0, 0, 0, "R8 post-update rise");
    cycle(0, 0, 0, 0, 0, 0, 0, "R2 idle");
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL R9 watchdog: got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule